// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare lane that sits beside a shared 16-bit timer count. A timer uses several of these lanes side by side, and each lane owns a single I/O pin. The lanes share nothing except the count and the tick, so each one runs on its own.

In capture mode the lane passes its pin through a two-stage synchroniser and looks for the selected edge. When it sees that edge, it stores the current count in its 16-bit register. A configuration bit can replace the pin with an internal radio event strobe as the capture source.

In compare mode the lane compares the count with its register on each prescaled tick. On a match it sets, clears or toggles its output pin. Every capture or compare event sets a sticky flag and sends a one-cycle DMA request pulse. The flag gated by an enable forms the interrupt request.

Top module: `tmr_cc_channel`

## Requirements
- R1: While reset is active and after it is released, `val_o`, `pin_o`, `flag_o`, `irq_o` and `dma_o` are all 0.
- R2: A level change on `pin_i` is captured on the third rising clock edge after the change. At that edge `val_o` takes the value of `count_i` present at that edge.
- R3: `edge_sel_i` selects the capture edge: 2'b01 is rising, 2'b10 is falling and 2'b11 is either edge. 2'b00 disables capture, and `val_o` does not change.
- R4: With `src_radio_i`=1, a high `radio_evt_i` at a clock edge captures `count_i` at that same edge, and pin edges are ignored.
- R5: With `cmp_mode_i`=1, a match occurs when `tick_i`=1 and `count_i` equals `val_o`. At that edge `pin_o` changes according to `cmp_act_i`: 2'b00 sets, 2'b01 clears, 2'b10 toggles and 2'b11 leaves the pin unchanged. If `tick_i`=0 there is no match.
- R6: Any capture or compare event sets `flag_o` at that edge. The flag then stays set until `flag_clr_i` is sampled high. An event in the same cycle as a clear wins, and the flag stays set.
- R7: `dma_o` is high for exactly the one cycle that follows each event edge.
- R8: `irq_o` is `flag_o` gated by `irq_en_i`.
- R9: A register write (`wr_i`) loads `wdata_i` into `val_o` at the next edge and takes priority over a capture in the same cycle.
- R10: With `cmp_mode_i`=0, `pin_o` holds its value. With `cmp_mode_i`=1, no captures happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Shared timer count |
| tick_i | input | 1 | Prescaled tick enable |
| pin_i | input | 1 | Asynchronous pin input |
| radio_evt_i | input | 1 | Internal radio capture strobe |
| cmp_mode_i | input | 1 | 1 = compare mode, 0 = capture mode |
| edge_sel_i | input | 2 | Capture edge select |
| src_radio_i | input | 1 | Capture source: 1 = radio strobe |
| cmp_act_i | input | 2 | Compare output action |
| irq_en_i | input | 1 | Interrupt enable |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| val_o | output | 16 | Capture/compare register |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA trigger pulse |

## Verification
The hardest case to reach from the ports is a flag clear and a new event that land on the same edge. The three-cycle synchroniser delay means the clear must be placed by counting cycles from the pin change. The bench drives the pin, waits two edges and then pulses the clear on the capture edge. It sets up a compare match against a clear in the same way, by loading the register with a count value a known number of cycles ahead. A register write that meets a capture is staged with the same cycle counting. A behavioural model runs next to the design and checks every output on every cycle.

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_i,
  input  logic         tick_i,
  input  logic         pin_i,
  input  logic         radio_evt_i,
  input  logic         cmp_mode_i,
  input  logic [1:0]   edge_sel_i,
  input  logic         src_radio_i,
  input  logic [1:0]   cmp_act_i,
  input  logic         irq_en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] val_o,
  output logic         pin_o,
  output logic         flag_o,
  output logic         irq_o,
  output logic         dma_o
);
  logic s1, s2, s3;
  logic rise, fall, pin_hit, cap_hit, cmp_hit, ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {pin_i, s1, s2};

  assign rise    = s2 & ~s3;
  assign fall    = ~s2 & s3;
  assign pin_hit = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
  assign cap_hit = ~cmp_mode_i & (src_radio_i ? radio_evt_i : pin_hit);
  assign cmp_hit = cmp_mode_i & tick_i & (count_i == val_o);
  assign ev      = cap_hit | cmp_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       val_o <= '0;
    else if (wr_i)    val_o <= wdata_i;
    else if (cap_hit) val_o <= count_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_o <= 1'b0;
    else if (cmp_hit)
      case (cmp_act_i)
        2'b00:   pin_o <= 1'b1;
        2'b01:   pin_o <= 1'b0;
        2'b10:   pin_o <= ~pin_o;
        default: pin_o <= pin_o;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_o <= 1'b0;
      dma_o  <= 1'b0;
    end else begin
      dma_o <= ev;
      if (ev)              flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] count_i,
  input logic         tick_i,
  input logic         cmp_mode_i,
  input logic [1:0]   cmp_act_i,
  input logic         irq_en_i,
  input logic         wr_i,
  input logic [W-1:0] wdata_i,
  input logic         flag_clr_i,
  input logic [W-1:0] val_o,
  input logic         pin_o,
  input logic         flag_o,
  input logic         irq_o,
  input logic         dma_o
);
  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode_i && tick_i && count_i == val_o && cmp_act_i == 2'b00) |=> pin_o);
  // R5
  cmp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode_i && tick_i && count_i == val_o && cmp_act_i == 2'b01) |=> !pin_o);
  // R10
  cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_mode_i |=> $stable(pin_o));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);
  // R7
  dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_o |-> flag_o);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en_i));
  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> val_o == $past(wdata_i));
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.W(W)) chk_i (.*);

// File: tb/tmr_cc_channel_tb_top.sv
module tmr_cc_channel_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] count_i = 0, wdata_i = 0;
  logic tick_i = 0, pin_i = 0, radio_evt_i = 0, cmp_mode_i = 0, src_radio_i = 0;
  logic irq_en_i = 0, wr_i = 0, flag_clr_i = 0;
  logic [1:0] edge_sel_i = 0, cmp_act_i = 0;
  logic [15:0] val_o;
  logic pin_o, flag_o, irq_o, dma_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr_cc_channel dut_i (.*);

  // behavioural reference
  logic [15:0] m_val;
  logic m_pin, m_flag, m_dma;
  logic hist[$];

  task automatic model_edge();
    logic cur, old, rise, fall, ph, cap, cmp;
    if (!rst_n) begin
      m_val = 0; m_pin = 0; m_flag = 0; m_dma = 0; hist = '{0, 0, 0};
      return;
    end
    cur = hist[1]; old = hist[2];
    rise = cur && !old; fall = !cur && old;
    ph = (edge_sel_i == 2'b01 && rise) || (edge_sel_i == 2'b10 && fall) ||
         (edge_sel_i == 2'b11 && (rise || fall));
    cap = !cmp_mode_i && (src_radio_i ? radio_evt_i : ph);
    cmp = cmp_mode_i && tick_i && (count_i == m_val);
    if (cmp) begin
      if (cmp_act_i == 2'b00) m_pin = 1;
      else if (cmp_act_i == 2'b01) m_pin = 0;
      else if (cmp_act_i == 2'b10) m_pin = !m_pin;
    end
    if (wr_i) m_val = wdata_i;
    else if (cap) m_val = count_i;
    if (cap || cmp) m_flag = 1;
    else if (flag_clr_i) m_flag = 0;
    m_dma = cap || cmp;
    hist.push_front(pin_i);
    void'(hist.pop_back());
  endtask

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R9 val", val_o, m_val);
    chk("R5/R10 pin", {15'd0, pin_o}, {15'd0, m_pin});
    chk("R6 flag", {15'd0, flag_o}, {15'd0, m_flag});
    chk("R7 dma", {15'd0, dma_o}, {15'd0, m_dma});
    chk("R8 irq", {15'd0, irq_o}, {15'd0, m_flag & irq_en_i});
  endtask

  // one cycle: inputs already set at negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    wr_i = 0; flag_clr_i = 0; radio_evt_i = 0;
    count_i = count_i + 1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hist = '{0, 0, 0};
    m_val = 0; m_pin = 0; m_flag = 0; m_dma = 0;
    @(negedge clk);
    steps(3);
    // R1 reset state
    chk("R1 val", val_o, 16'd0);
    chk("R1 flags", {12'd0, pin_o, flag_o, irq_o, dma_o}, 16'd0);
    rst_n = 1;
    steps(2);
    chk("R1 after release", {12'd0, pin_o, flag_o, irq_o, dma_o}, 16'd0);

    // R2 / R3 rising capture
    edge_sel_i = 2'b01; irq_en_i = 1;
    pin_i = 1; steps(6);
    pin_i = 0; steps(6);           // falling ignored in rising mode (R3)
    flag_clr_i = 1; steps(2);
    // R3 falling
    edge_sel_i = 2'b10;
    pin_i = 1; steps(5); pin_i = 0; steps(5);
    // R3 either edge
    edge_sel_i = 2'b11;
    pin_i = 1; steps(4); pin_i = 0; steps(4);
    // R3 disabled
    edge_sel_i = 2'b00; flag_clr_i = 1; steps(1);
    pin_i = 1; steps(4); pin_i = 0; steps(4);
    // R6 clear vs capture on the same edge: pin change, then clear at 3rd edge
    edge_sel_i = 2'b01; pin_i = 1; steps(2); flag_clr_i = 1; steps(3);
    // R9 write wins over capture
    pin_i = 0; steps(4); pin_i = 1; steps(2);
    wr_i = 1; wdata_i = 16'h5A5A; steps(3);
    // R4 radio source, pin ignored
    src_radio_i = 1; irq_en_i = 0;
    pin_i = 0; steps(4); pin_i = 1; steps(4);
    radio_evt_i = 1; steps(3);
    src_radio_i = 0;

    // R5 / R10 compare mode
    cmp_mode_i = 1; flag_clr_i = 1; steps(1);
    irq_en_i = 1;
    for (int a = 0; a < 4; a++) begin
      cmp_act_i = a[1:0];
      wr_i = 1; wdata_i = count_i + 16'd3; tick_i = 1; steps(6);
      wr_i = 1; wdata_i = count_i + 16'd3; steps(6);
    end
    // R5 no match without tick
    cmp_act_i = 2'b10; tick_i = 0;
    wr_i = 1; wdata_i = count_i + 16'd2; steps(5);
    // R10 pin edges do not capture in compare mode
    pin_i = 0; steps(4); pin_i = 1; steps(4);
    // R6 compare event vs clear on same edge
    tick_i = 1; wr_i = 1; wdata_i = count_i + 16'd2; steps(2);
    flag_clr_i = 1; steps(3);
    flag_clr_i = 1; steps(2);
    // R8 gating toggled with flag set
    wr_i = 1; wdata_i = count_i + 16'd2; steps(4);
    irq_en_i = 0; steps(2); irq_en_i = 1; steps(2);
    // R10 back in capture mode pin holds
    cmp_mode_i = 0; steps(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule